// File: doc/BRIEF.md
# Nibble-Wide Return Address Stack Sequencer

This block saves a 13-bit program counter to a stack held in a memory that stores one 4-bit nibble per word. It restores the counter from the same stack. An 8-bit stack pointer inside the block addresses the stack. A save request splits the low twelve counter bits into three nibbles and writes them on three consecutive cycles. Each write goes to a pointer that the block decrements just before the write. A restore request reads three nibbles back on three consecutive cycles, incrementing the pointer after each read, and reassembles the counter.

The top counter bit selects a bank and never enters the stack. A restore keeps the bank bit the caller presents with the request. A single-cycle done strobe marks the end of every sequence. The restored counter is held on its output until the next restore completes.

The memory is modelled as asynchronous-read. Read data is sampled in the same cycle that the address is driven. Only the low nibble of the read word is used.

Top module: `nib_stack_seq`

## Requirements
- R1: After reset the block is idle: `done`, `mem_we` and `pc_out` are all zero, and the stack pointer holds `SP_RESET` (default 0). The first save therefore writes first at address `SP_RESET-1`.
- R2: Every save write goes to the stack pointer minus one, and the pointer takes that decremented value at the end of the write cycle.
- R3: A save writes `pc_in[11:8]`, then `pc_in[7:4]`, then `pc_in[3:0]`. The three writes fall on the three cycles that follow the edge accepting the request, with `mem_we` high in exactly those cycles.
- R4: Every restore read uses the current stack pointer as its address and then increments the pointer. Only bits [3:0] of `mem_rdata` are used, and the upper bits have no effect on `pc_out`.
- R5: A restore places the first nibble read in `pc_out[3:0]`, the second in `pc_out[7:4]` and the third in `pc_out[11:8]`.
- R6: Bit 12 of the counter is never written to memory. After a restore, `pc_out[12]` equals `pc_in[12]` as sampled on the edge that accepted the restore.
- R7: The stack pointer wraps modulo 256 in both directions (0 minus 1 gives 255, 255 plus 1 gives 0), with no overflow indication.
- R8: `done` is high for exactly one cycle, the cycle after the third nibble. A save leaves `pc_out` unchanged. A restore updates `pc_out` in the same cycle that `done` rises.
- R9: Save and restore requests seen during the three nibble cycles are ignored: they cause no extra memory write, no extra `done` and no pointer change.
- R10: When save and restore requests arrive in the same idle cycle, the save is performed and the restore is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_req | input | 1 | Request to save `pc_in` on the stack |
| pop_req | input | 1 | Request to restore a counter from the stack |
| pc_in | input | 13 | Current program counter; bit 12 is the bank bit |
| mem_rdata | input | 8 | Read data from the stack memory (low nibble used) |
| mem_addr | output | 8 | Stack memory address |
| mem_wdata | output | 4 | Nibble to write |
| mem_we | output | 1 | Write enable for the stack memory |
| pc_out | output | 13 | Last restored program counter |
| done | output | 1 | One-cycle pulse at the end of a save or restore |

## Verification
A request is presented at a falling edge and accepted at the next rising edge. The three memory writes are due in the three cycles that follow. `done` and the restored counter are due in the fourth cycle, and `done` is low again in the fifth. The driver pushes each expected write and each expected counter into scoreboard queues. A monitor samples on falling edges, so it reads settled values between rising edges. It pops an entry whenever `mem_we` or `done` is seen, and flags any activity it was not told to expect. The driver itself checks `done` at the fourth and fifth falling edges after acceptance, so a pulse that lands one cycle early or late is caught.

// File: rtl/nsq_pkg.sv
package nsq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_SAVE = 2'd1,
        SEQ_LOAD = 2'd2
    } seq_mode_e;

endpackage

// File: rtl/nsq_sp_reg.sv
module nsq_sp_reg #(
    parameter int          SP_W     = 8,
    parameter logic [SP_W-1:0] SP_RESET = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dec_en,
    input  logic            inc_en,
    output logic [SP_W-1:0] sp_q
);

    logic [SP_W-1:0] sp_d;

    always_comb begin
        sp_d = sp_q;
        if (dec_en)
            sp_d = sp_q - SP_W'(1);
        else if (inc_en)
            sp_d = sp_q + SP_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sp_q <= SP_RESET;
        else
            sp_q <= sp_d;
    end

    // R7: pointer only moves when asked
    p_sp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_en || inc_en) |=> $stable(sp_q));

    // R10: never both directions at once
    p_sp_one_dir_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dec_en, inc_en}));

endmodule

// File: rtl/nsq_nib_split.sv
module nsq_nib_split #(
    parameter int NIB_W   = 4,
    parameter int NIBBLES = 3,
    parameter int STEP_W  = 2
) (
    input  logic [NIBBLES*NIB_W-1:0] word,
    input  logic [STEP_W-1:0]        step,
    output logic [NIB_W-1:0]         nib
);

    // lane k holds the nibble emitted at step k: most significant first
    logic [NIB_W-1:0] lane [NIBBLES];

    for (genvar k = 0; k < NIBBLES; k++) begin : g_lane
        assign lane[k] = word[(NIBBLES-1-k)*NIB_W +: NIB_W];
    end

    always_comb begin
        nib = '0;
        for (int k = 0; k < NIBBLES; k++) begin
            if (step == STEP_W'(k))
                nib = lane[k];
        end
    end

endmodule

// File: rtl/nib_stack_seq.sv
module nib_stack_seq
    import nsq_pkg::*;
#(
    parameter int              PC_W     = 13,
    parameter int              NIB_W    = 4,
    parameter int              SP_W     = 8,
    parameter int              MEM_W    = 8,
    parameter logic [SP_W-1:0] SP_RESET = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             pop_req,
    input  logic [PC_W-1:0]  pc_in,
    input  logic [MEM_W-1:0] mem_rdata,
    output logic [SP_W-1:0]  mem_addr,
    output logic [NIB_W-1:0] mem_wdata,
    output logic             mem_we,
    output logic [PC_W-1:0]  pc_out,
    output logic             done
);

    localparam int NIBBLES = (PC_W - 1) / NIB_W;
    localparam int STEP_W  = (NIBBLES > 1) ? $clog2(NIBBLES) : 1;
    localparam int BANK    = PC_W - 1;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NIBBLES - 1);

    typedef struct packed {
        seq_mode_e         mode;
        logic [STEP_W-1:0] step;
        logic [PC_W-1:0]   hold;
        logic [PC_W-1:0]   pc_out;
        logic              done;
    } seq_state_t;

    seq_state_t s_d, s_q;

    logic [SP_W-1:0]  sp_q;
    logic [NIB_W-1:0] save_nib;
    logic [NIB_W-1:0] rd_nib;
    logic             saving, loading;

    assign saving  = (s_q.mode == SEQ_SAVE);
    assign loading = (s_q.mode == SEQ_LOAD);
    assign rd_nib  = NIB_W'(mem_rdata);

    nsq_sp_reg #(
        .SP_W     (SP_W),
        .SP_RESET (SP_RESET)
    ) u_sp (
        .clk    (clk),
        .rst_n  (rst_n),
        .dec_en (saving),
        .inc_en (loading),
        .sp_q   (sp_q)
    );

    nsq_nib_split #(
        .NIB_W   (NIB_W),
        .NIBBLES (NIBBLES),
        .STEP_W  (STEP_W)
    ) u_split (
        .word (s_q.hold[NIBBLES*NIB_W-1:0]),
        .step (s_q.step),
        .nib  (save_nib)
    );

    // memory side: pre-decremented address on save, current pointer on load
    assign mem_addr  = saving ? (sp_q - SP_W'(1)) : sp_q;
    assign mem_wdata = saving ? save_nib : '0;
    assign mem_we    = saving;
    assign pc_out    = s_q.pc_out;
    assign done      = s_q.done;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.mode)
            SEQ_IDLE: begin
                s_d.step = '0;
                if (push_req) begin
                    s_d.mode = SEQ_SAVE;
                    s_d.hold = pc_in;
                end else if (pop_req) begin
                    s_d.mode       = SEQ_LOAD;
                    s_d.hold       = '0;
                    s_d.hold[BANK] = pc_in[BANK];
                end
            end
            SEQ_SAVE: begin
                s_d.step = s_q.step + STEP_W'(1);
                if (s_q.step == LAST_STEP) begin
                    s_d.mode = SEQ_IDLE;
                    s_d.step = '0;
                    s_d.done = 1'b1;
                end
            end
            SEQ_LOAD: begin
                for (int k = 0; k < NIBBLES; k++) begin
                    if (s_q.step == STEP_W'(k))
                        s_d.hold[k*NIB_W +: NIB_W] = rd_nib;
                end
                s_d.step = s_q.step + STEP_W'(1);
                if (s_q.step == LAST_STEP) begin
                    s_d.mode   = SEQ_IDLE;
                    s_d.step   = '0;
                    s_d.done   = 1'b1;
                    s_d.pc_out = s_d.hold;
                end
            end
            default: begin
                s_d.mode = SEQ_IDLE;
                s_d.step = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mode   <= SEQ_IDLE;
            s_q.step   <= '0;
            s_q.hold   <= '0;
            s_q.pc_out <= '0;
            s_q.done   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    // R2: each write lands where the pointer ends up
    p_write_predec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (sp_q == $past(mem_addr)));

    // R4: each restore read is followed by a pointer increment
    p_read_postinc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        loading |=> (sp_q == $past(sp_q) + SP_W'(1)));

    // R6: captured bank bit is not disturbed during a restore
    p_bank_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        loading |=> $stable(s_q.hold[BANK]));

    // R8: done is a single-cycle strobe
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: done follows the final nibble cycle
    p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(s_q.mode) != SEQ_IDLE) && ($past(s_q.step) == LAST_STEP));

    // R9: a running sequence is never restarted
    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode != SEQ_IDLE && s_q.step != LAST_STEP) |=> $stable(s_q.mode));

    // R8: save never alters the restored counter
    p_save_keeps_pc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        saving |=> $stable(pc_out));

endmodule

// File: tb/nib_stack_seq_tb.sv
module nib_stack_seq_tb;

    localparam int PC_W  = 13;
    localparam int SP_W  = 8;
    localparam int MEM_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             push_req = 1'b0;
    logic             pop_req = 1'b0;
    logic [PC_W-1:0]  pc_in = '0;
    logic [MEM_W-1:0] mem_rdata;
    logic [SP_W-1:0]  mem_addr;
    logic [3:0]       mem_wdata;
    logic             mem_we;
    logic [PC_W-1:0]  pc_out;
    logic             done;

    always #4 clk = ~clk;

    nib_stack_seq u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (push_req),
        .pop_req   (pop_req),
        .pc_in     (pc_in),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .pc_out    (pc_out),
        .done      (done)
    );

    // stack memory model: upper nibble always carries junk (R4)
    logic [MEM_W-1:0] mem [256];
    initial begin
        for (int k = 0; k < 256; k++)
            mem[k] = {4'hA, 4'(k) ^ 4'h6};
    end
    always @(posedge clk) begin
        if (mem_we)
            mem[mem_addr] <= {4'h5, mem_wdata};
    end
    assign mem_rdata = mem[mem_addr];

    int checks = 0;
    int errors = 0;
    string cur_tag = "R1";
    logic [SP_W-1:0] exp_sp = '0;
    logic [PC_W-1:0] last_pc = '0;
    logic [11:0] wq [$];
    logic [PC_W-1:0] dq [$];

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", cur_tag, what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                if (wq.size() == 0) begin
                    check(1'b0, "unexpected write (R9)", {mem_addr, mem_wdata}, 0);
                end else begin
                    logic [11:0] e;
                    e = wq.pop_front();
                    check({mem_addr, mem_wdata} == e, "write addr/data (R2 R3)",
                          {mem_addr, mem_wdata}, e);
                end
            end
            if (done) begin
                if (dq.size() == 0) begin
                    check(1'b0, "unexpected done (R9)", pc_out, 0);
                end else begin
                    logic [PC_W-1:0] e;
                    e = dq.pop_front();
                    check(pc_out == e, "pc_out at done (R5 R6 R8)", pc_out, e);
                end
            end
        end
    end

    // driver: one sequence, optional noise request on the busy cycles
    task automatic run_seq(input bit do_push, input bit do_pop, input logic [PC_W-1:0] pc,
                           input bit noise_push, input bit noise_pop, input string tag);
        cur_tag = tag;
        if (do_push) begin
            for (int k = 0; k < 3; k++) begin
                exp_sp = exp_sp - 8'd1;
                wq.push_back({exp_sp, pc[(2-k)*4 +: 4]});
            end
            dq.push_back(last_pc);
        end else if (do_pop) begin
            logic [PC_W-1:0] r;
            r[PC_W-1] = pc[PC_W-1];
            for (int k = 0; k < 3; k++) begin
                r[k*4 +: 4] = mem[exp_sp][3:0];
                exp_sp = exp_sp + 8'd1;
            end
            last_pc = r;
            dq.push_back(r);
        end
        @(negedge clk);
        push_req = do_push;
        pop_req  = do_pop;
        pc_in    = pc;
        @(negedge clk);
        push_req = noise_push;
        pop_req  = noise_pop;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        push_req = 1'b0;
        pop_req  = 1'b0;
        check(done == 1'b1, "done high 4th cycle (R8)", done, 1);
        @(negedge clk);
        check(done == 1'b0, "done low 5th cycle (R8)", done, 0);
        check(mem_we == 1'b0, "idle no write (R9)", mem_we, 0);
    endtask

    bit finished = 0;

    initial begin
        #(8 * 20000);
        if (!finished) begin
            cur_tag = "watchdog";
            check(1'b0, "run did not finish", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_tag = "R1";
        check(done == 1'b0, "reset done", done, 0);
        check(mem_we == 1'b0, "reset we", mem_we, 0);
        check(pc_out == '0, "reset pc_out", pc_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0 && mem_we == 1'b0, "idle after reset", {done, mem_we}, 0);

        // R1 R7: first save from pointer 0 wraps to 255
        run_seq(1, 0, 13'h1ABC, 0, 0, "R1 R7 R2 R3");
        // R4 R5 R6 R7: restore wraps 255 -> 0, bank from request
        run_seq(0, 1, 13'h0000, 0, 0, "R4 R5 R6 R7");
        // restore preloaded data with bank set
        run_seq(0, 1, 13'h1000, 0, 0, "R4 R5 R6");
        // R9: pop noise during a save
        run_seq(1, 0, 13'h0123, 0, 1, "R9 save");
        // R10: both requests together, save wins
        run_seq(1, 1, 13'h1F0E, 0, 0, "R10");
        // R9: push noise during a restore
        run_seq(0, 1, 13'h0FFF, 1, 0, "R9 restore");
        // mixed patterns, bank toggling
        for (int i = 0; i < 6; i++) begin
            logic [PC_W-1:0] v;
            v = PC_W'((i * 13'h0735) ^ 13'h0A5C);
            run_seq(1, 0, v, 0, 0, "R2 R3");
            run_seq(1, 0, ~v, 0, 0, "R2 R3");
            run_seq(0, 1, {i[0], 12'h000}, 0, 0, "R5 R6");
            run_seq(0, 1, {~i[0], 12'h000}, 0, 0, "R5 R6");
        end
        repeat (3) @(negedge clk);
        cur_tag = "R9";
        check(wq.size() == 0, "writes left pending", wq.size(), 0);
        check(dq.size() == 0, "done events left pending", dq.size(), 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule